// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

This block converts a parallel word into a serial bit stream. A word on the parallel inputs is first captured into a holding register when the store strobe fires. Later, or in the same cycle, an active-low load control copies the holding register into a shift register. Each shift strobe then moves the shift register one stage toward the serial output and takes a fresh bit from the serial input. An active-low clear empties the shift register without touching the holding register. The next word can therefore be staged while the current one is still being shifted out.

Both strobes are single-cycle pulses in the system clock domain and act independently. Load and clear are level controls and take effect at the next system clock edge. A synchronous reset empties both registers.

Top module: `pisoBufShifter`

## Requirements
- R1: A store strobe captures the parallel inputs into the holding register at the next clock edge. Load, clear and shift strobe have no effect on this capture.
- R2: With load low and clear high, the shift register takes the holding register contents, with parIn[k] going to stage k. Any shift strobe in that cycle is ignored.
- R3: When load is low and a store strobe occurs in the same cycle, the shift register takes the parallel inputs of that cycle directly.
- R4: With clear low and load high, the shift register is emptied to all zeros, overriding any shift strobe. The holding register keeps its value.
- R5: With clear and load both low, clear wins: the shift register holds all zeros while both are low.
- R6: With load and clear high, a shift strobe moves stage k-1 into stage k and serIn into stage 0. serOut always shows stage WIDTH-1, so a loaded word leaves MSB first.
- R7: With no strobe and load and clear both high, the shift register keeps its value.
- R8: A synchronous reset empties both the holding register and the shift register, and serOut reads 0.
- R9: A store strobe and a shift strobe in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| storeStrobe | input | 1 | One-cycle pulse that captures parIn into the holding register |
| shiftStrobe | input | 1 | One-cycle pulse that advances the shift register |
| loadN | input | 1 | Active-low level: copy the holding register into the shift register |
| clearN | input | 1 | Active-low level: empty the shift register |
| parIn | input | WIDTH | Parallel data word |
| serIn | input | 1 | Bit entering stage 0 on a shift |
| serOut | output | 1 | Last stage of the shift register |

## Verification
The bench builds the block with WIDTH = 4. At that width all 16 words can be swept, each through a staged load, a pass-through load and a serial fill. Every shift-register value is read back by shifting it out and comparing it against the word computed in the bench. At four stages, the priority cases (clear over load, load over shift, and a store during a shift) each take only a few cycles to observe at serOut.

// File: rtl/pisoPkg.sv
package pisoPkg;
  // Decoded per-cycle commands, from control to datapath
  typedef struct packed {
    logic capture;  // holding register takes parIn
    logic clear;    // shift register empties
    logic load;     // shift register takes the load source
    logic shift;    // shift register advances one stage
  } pisoCmd_t;
endpackage

// File: rtl/pisoCtrl.sv
module pisoCtrl
  import pisoPkg::*;
(
  input  logic     storeStrobe,
  input  logic     shiftStrobe,
  input  logic     loadN,
  input  logic     clearN,
  output pisoCmd_t cmd
);
  logic clearReq;
  logic loadReq;

  always_comb begin
    clearReq    = !clearN;
    loadReq     = !loadN;
    cmd.capture = storeStrobe;
    // clear outranks load, load outranks shift
    cmd.clear   = clearReq;
    cmd.load    = loadReq && !clearReq;
    cmd.shift   = shiftStrobe && !loadReq && !clearReq;
  end
endmodule

// File: rtl/pisoDatapath.sv
module pisoDatapath
  import pisoPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pisoCmd_t         cmd,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] storeReg;
  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] loadSrc;
  logic [WIDTH-1:0] shiftNext;

  // Holding register
  always_ff @(posedge clk) begin
    if (rst)              storeReg <= '0;
    else if (cmd.capture) storeReg <= parIn;
  end

  // A capture in the load cycle passes the new word straight through
  assign loadSrc = cmd.capture ? parIn : storeReg;

  // Per-stage shifted value
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign shiftNext[k] = serIn;
    end else begin : g_body
      assign shiftNext[k] = shiftReg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            shiftReg <= '0;
    else if (cmd.clear) shiftReg <= '0;
    else if (cmd.load)  shiftReg <= loadSrc;
    else if (cmd.shift) shiftReg <= shiftNext;
  end

  assign serOut = shiftReg[LAST];

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (shiftReg == '0 && storeReg == '0));

  // R1
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.capture |=> storeReg == $past(parIn));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.load && !cmd.capture) |=> shiftReg == $past(storeReg));

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.load && cmd.capture) |=> shiftReg == $past(parIn));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.clear |=> shiftReg == '0);

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.shift |=> (shiftReg[0] == $past(serIn) && serOut == $past(shiftReg[LAST-1])));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd.clear || cmd.load || cmd.shift) |=> $stable(shiftReg));
endmodule

// File: rtl/pisoBufShifter.sv
module pisoBufShifter
  import pisoPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             storeStrobe,
  input  logic             shiftStrobe,
  input  logic             loadN,
  input  logic             clearN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut
);
  pisoCmd_t cmd;

  pisoCtrl u_ctrl (
    .storeStrobe(storeStrobe),
    .shiftStrobe(shiftStrobe),
    .loadN      (loadN),
    .clearN     (clearN),
    .cmd        (cmd)
  );

  pisoDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .parIn (parIn),
    .serIn (serIn),
    .serOut(serOut)
  );
endmodule

// File: tb/pisoBufShifter_bench.sv
module pisoBufShifter_bench;
  localparam int W = 4;
  localparam int NWORD = 1 << W;

  logic clk = 1'b0;
  logic rst, storeStrobe, shiftStrobe, loadN, clearN, serIn;
  logic [W-1:0] parIn;
  logic serOut;
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  pisoBufShifter #(.WIDTH(W)) u_pisoBufShifter (
    .clk(clk), .rst(rst), .storeStrobe(storeStrobe), .shiftStrobe(shiftStrobe),
    .loadN(loadN), .clearN(clearN), .parIn(parIn), .serIn(serIn), .serOut(serOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    storeStrobe = 1'b0; shiftStrobe = 1'b0; loadN = 1'b1; clearN = 1'b1; serIn = 1'b0;
  endtask

  // Shift the register out MSB first; zeros enter at stage 0
  task automatic readWord(output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      w[W-1-i] = serOut;
      serIn = 1'b0; shiftStrobe = 1'b1;
      cyc();
    end
    shiftStrobe = 1'b0;
  endtask

  task automatic stageLoad(input logic [W-1:0] v);
    idle(); parIn = v; storeStrobe = 1'b1; cyc();
    idle(); parIn = ~v; loadN = 1'b0; shiftStrobe = 1'b1; cyc();
    idle();
  endtask

  initial begin
    logic [W-1:0] got;
    rst = 1'b1; idle(); parIn = '0;
    repeat (3) cyc();
    rst = 1'b0;
    // R8: reset state
    chk("R8 serOut", serOut, 0);
    loadN = 1'b0; cyc(); idle();
    readWord(got); chk("R8 holding cleared", got, 0);

    // R1 R2: staged load for every word, shift strobe ignored
    for (int v = 0; v < NWORD; v++) begin
      stageLoad(v[W-1:0]);
      chk("R6 first bit", serOut, (v >> (W-1)) & 1);
      readWord(got); chk("R2 staged load", got, v);
      readWord(got); chk("R6 zeros fill", got, 0);
    end

    // R1: capture while clear low and shift strobe high
    for (int v = 0; v < NWORD; v += 5) begin
      idle(); parIn = v[W-1:0]; storeStrobe = 1'b1; clearN = 1'b0; shiftStrobe = 1'b1; cyc();
      idle(); parIn = '0; loadN = 1'b0; cyc(); idle();
      readWord(got); chk("R1 capture under clear", got, v);
    end

    // R3: pass-through load
    for (int v = 0; v < NWORD; v++) begin
      idle(); parIn = v[W-1:0]; storeStrobe = 1'b1; loadN = 1'b0; cyc(); idle();
      chk("R3 first bit", serOut, (v >> (W-1)) & 1);
      readWord(got); chk("R3 pass-through", got, v);
    end

    // R6: serial fill of every word, MSB first
    for (int v = 0; v < NWORD; v++) begin
      idle(); clearN = 1'b0; cyc(); idle();
      for (int i = W - 1; i >= 0; i--) begin
        serIn = v[i]; shiftStrobe = 1'b1; cyc();
      end
      idle();
      readWord(got); chk("R6 serial fill", got, v);
    end

    // R4: clear overrides shift, holding register kept
    stageLoad(4'hB);
    idle(); clearN = 1'b0; shiftStrobe = 1'b1; serIn = 1'b1; cyc(); idle();
    chk("R4 serOut after clear", serOut, 0);
    readWord(got); chk("R4 cleared", got, 0);
    loadN = 1'b0; cyc(); idle();
    readWord(got); chk("R4 holding kept", got, 4'hB);

    // R5: both low, clear wins while held
    stageLoad(4'hF);
    idle(); clearN = 1'b0; loadN = 1'b0; cyc();
    chk("R5 serOut both low", serOut, 0);
    cyc();
    chk("R5 serOut still low", serOut, 0);
    idle(); clearN = 1'b0; cyc(); idle();

    // R7: hold without strobes
    stageLoad(4'h9);
    repeat (5) cyc();
    chk("R7 hold serOut", serOut, 1);
    readWord(got); chk("R7 hold", got, 4'h9);

    // R9: store and shift in one cycle
    stageLoad(4'h6);
    idle(); parIn = 4'hA; storeStrobe = 1'b1; shiftStrobe = 1'b1; serIn = 1'b1; cyc(); idle();
    readWord(got); chk("R9 shift taken", got, 4'hD);
    loadN = 1'b0; cyc(); idle();
    readWord(got); chk("R9 store taken", got, 4'hA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule